// File: doc/BRIEF.md
# Test coprocessor register file

This block is a small verification-aid coprocessor attached to a host core. It holds sixteen 32-bit registers that the core can write or read one at a time, or move through multi-word block loads and stores. It also runs a stall command: the core is held in a busy handshake for a number of clock cycles taken from one of its registers. Interrupt generation is not part of this block.

Every cycle the core presents a cycle kind, a transfer class, the instruction word and write data. The block answers in the same cycle with a response code and, for reads and stores, the read data. Register writes and internal state updates take effect at the next rising clock edge. A free-running cycle counter that starts at zero after reset supplies the time base for the stall command.

Encodings used throughout: cycle kind 0 = idle, 1 = first, 2 = busy, 3 = data. Class 0 = register write, 1 = register read, 2 = block load, 3 = block store, 4 = data-processing; codes 5 to 7 are unused. Response 0 = done, 1 = busy, 2 = increment, 3 = cannot.

Top module: `tcop_top`

## Requirements
- R1: After reset every register reads as zero and an idle cycle answers done (0).
- R2: A register-write class on a data cycle stores wdata into the register named by instr[19:16] and answers done; on any other cycle kind it writes nothing.
- R3: A register-read class on a data cycle drives rdata with the register named by instr[19:16] in the same cycle and answers done.
- R4: A block load on a data cycle stores wdata into the register named by instr[15:12]; with instr[22] clear it answers done after that single word.
- R5: With instr[22] set, a block load or store keeps a word counter that starts at zero; each data cycle answers increment (2) while the counter is below 4 and done when it equals 4, then the counter advances, so the fifth word finishes the transfer. Every word uses the same register.
- R6: A first or busy cycle of a block load or store clears its word counter and answers done.
- R7: A block store on a data cycle drives rdata with the register named by instr[15:12] and follows the same done/increment sequence as a load.
- R8: A data-processing command with instr[23:20] = 0 on its first cycle reads a delay from the register named by instr[3:0], sets a deadline of cycle count plus delay, and answers done if the delay is zero, else busy (1).
- R9: On busy cycles of that command the answer is busy until the cycle counter is at or past the deadline, then done; with back-to-back busy cycles, done arrives exactly delay cycles after the first cycle.
- R10: A data-processing command with any other opcode, or an unused class code, answers cannot (3) on every non-idle cycle.
- R11: An idle cycle answers done, writes no register and leaves a block word counter unchanged, so a long transfer resumes where it paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 2 | Cycle kind of the current handshake cycle |
| cls_i | input | 3 | Transfer class of the current command |
| instr_i | input | 32 | Instruction word carrying register selects and opcode |
| wdata_i | input | 32 | Data from the core for writes and block loads |
| rdata_o | output | 32 | Data to the core for reads and block stores |
| resp_o | output | 2 | Handshake response for this cycle |

## Verification
On every cycle the assertions check that a register written through either write path holds the written value one edge later, that the cycle counter advances by one, that the stall deadline only moves on a first cycle, that the block word counter steps once per increment answer and clears on non-data cycles, that increment only appears for block classes, and that a stall that has answered done stays done. Only the bench scenarios show the exact response sequences: the five-word long transfers with a pause in the middle, the count of busy answers for delays of zero, one and three, a late busy cycle arriving after the deadline, and the registers' contents after each kind of transfer.

// File: rtl/tcop_pkg.sv
package tcop_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_FIRST = 2'd1,
      CYC_BUSY  = 2'd2,
      CYC_DATA  = 2'd3
   } cyc_e;

   typedef enum logic [2:0] {
      CLS_WR  = 3'd0,
      CLS_RD  = 3'd1,
      CLS_BLD = 3'd2,
      CLS_BST = 3'd3,
      CLS_DP  = 3'd4
   } cls_e;

   typedef enum logic [1:0] {
      RSP_DONE = 2'd0,
      RSP_BUSY = 2'd1,
      RSP_INC  = 2'd2,
      RSP_CANT = 3'd3
   } rsp_e;

endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile #(
   parameter int DATA_W = 32,
   parameter int NREG   = 16,
   localparam int AW    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [AW-1:0]     widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     ridx_a_i,
   input  logic [AW-1:0]     ridx_b_i,
   input  logic [AW-1:0]     ridx_c_i,
   output logic [DATA_W-1:0] rdata_a_o,
   output logic [DATA_W-1:0] rdata_b_o,
   output logic [DATA_W-1:0] rdata_c_o
);

   logic [DATA_W-1:0] regs [NREG];

   generate
      if (NREG < 2 || NREG > 16 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("tcop_regfile: NREG must be a power of two between 2 and 16");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("tcop_regfile: DATA_W must be at least 8");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (we_i && widx_i == AW'(g))
               regs[g] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_a_o = regs[ridx_a_i];
   assign rdata_b_o = regs[ridx_b_i];
   assign rdata_c_o = regs[ridx_c_i];

   // R2 / R4: a write lands in the addressed register at the next edge
   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> regs[$past(widx_i)] == $past(wdata_i));

endmodule

// File: rtl/tcop_blk_seq.sv
module tcop_blk_seq
   import tcop_pkg::*;
#(
   parameter int LONG_LAST = 4,
   localparam int WC_W     = $clog2(LONG_LAST + 1) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic data_i,
   input  logic long_i,
   output rsp_e rsp_o
);

   logic [WC_W-1:0] wcnt_q;
   localparam logic [WC_W-1:0] WC_MAX  = '1;
   localparam logic [WC_W-1:0] WC_LAST = WC_W'(LONG_LAST);

   generate
      if (LONG_LAST < 1) begin : g_bad_last
         $error("tcop_blk_seq: LONG_LAST must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wcnt_q <= '0;
      else if (active_i) begin
         if (!data_i)
            wcnt_q <= '0;
         else if (long_i && wcnt_q != WC_MAX)
            wcnt_q <= wcnt_q + 1'b1;
      end
   end

   always_comb begin
      rsp_o = RSP_DONE;
      if (active_i && data_i && long_i && wcnt_q != WC_LAST)
         rsp_o = RSP_INC;
   end

   // R5: every increment answer is followed by one counter step
   assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && data_i && rsp_o == RSP_INC) |=> wcnt_q == $past(wcnt_q) + 1'b1);

   // R6: a non-data cycle of the transfer leaves the counter at zero
   assert_word_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !data_i) |=> wcnt_q == '0);

   // R11: an inactive cycle leaves the counter untouched
   assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> $stable(wcnt_q));

endmodule

// File: rtl/tcop_delay.sv
module tcop_delay #(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] delay_i,
   output logic              wait_o
);

   logic [CNT_W-1:0] now_q;
   logic [CNT_W-1:0] deadline_q;
   logic             reached;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("tcop_delay: CNT_W must lie between 2 and DATA_W");
      end
      if (WRAP_SAFE) begin : g_cmp_wrap
         logic [CNT_W-1:0] diff;
         assign diff    = now_q - deadline_q;
         assign reached = ~diff[CNT_W-1];
      end else begin : g_cmp_plain
         assign reached = now_q >= deadline_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         now_q <= '0;
      else
         now_q <= now_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         deadline_q <= '0;
      else if (first_i)
         deadline_q <= now_q + delay_i[CNT_W-1:0];
   end

   always_comb begin
      wait_o = 1'b0;
      if (first_i)
         wait_o = delay_i != '0;
      else if (busy_i)
         wait_o = !reached;
   end

   // R9: the time base advances by one every clock once out of reset
   assert_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> now_q == $past(now_q) + 1'b1);

   // R8: the deadline only moves on a first cycle
   assert_deadline_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !first_i |=> $stable(deadline_q));

endmodule

// File: rtl/tcop_top.sv
module tcop_top
   import tcop_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NREG      = 16,
   parameter int CNT_W     = 32,
   parameter int LONG_LAST = 4,
   parameter bit WRAP_SAFE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cyc_i,
   input  logic [2:0]        cls_i,
   input  logic [31:0]       instr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [1:0]        resp_o
);

   localparam int AW = $clog2(NREG);

   cyc_e cyc;
   cls_e cls;
   assign cyc = cyc_e'(cyc_i);
   assign cls = cls_e'(cls_i);

   logic [AW-1:0]     idx_single, idx_blk, idx_dly;
   logic [DATA_W-1:0] rd_single, rd_blk, rd_dly;
   logic              we;
   logic [AW-1:0]     widx;
   logic              is_data, is_active, long_f;
   logic              dp_sel, dp_op0, dp_first, dp_busy, dly_wait;
   rsp_e              blk_rsp [2];
   rsp_e              rsp;

   assign idx_single = instr_i[16 +: AW];
   assign idx_blk    = instr_i[12 +: AW];
   assign idx_dly    = instr_i[0 +: AW];
   assign is_data    = cyc == CYC_DATA;
   assign is_active  = cyc != CYC_IDLE;
   assign long_f     = instr_i[22];

   // one write port shared by single writes and block loads
   always_comb begin
      we   = 1'b0;
      widx = idx_single;
      if (is_data && cls == CLS_WR) begin
         we   = 1'b1;
         widx = idx_single;
      end else if (is_data && cls == CLS_BLD) begin
         we   = 1'b1;
         widx = idx_blk;
      end
   end

   tcop_regfile #(.DATA_W(DATA_W), .NREG(NREG)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (we),
      .widx_i    (widx),
      .wdata_i   (wdata_i),
      .ridx_a_i  (idx_single),
      .ridx_b_i  (idx_blk),
      .ridx_c_i  (idx_dly),
      .rdata_a_o (rd_single),
      .rdata_b_o (rd_blk),
      .rdata_c_o (rd_dly)
   );

   // one word-count sequencer per direction: index 0 load, 1 store
   generate
      for (genvar d = 0; d < 2; d++) begin : g_blk
         logic act;
         assign act = is_active && (cls == (d == 0 ? CLS_BLD : CLS_BST));
         tcop_blk_seq #(.LONG_LAST(LONG_LAST)) seq_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (act),
            .data_i   (is_data),
            .long_i   (long_f),
            .rsp_o    (blk_rsp[d])
         );
      end
   endgenerate

   assign dp_sel   = cls == CLS_DP;
   assign dp_op0   = dp_sel && instr_i[23:20] == 4'd0;
   assign dp_first = dp_op0 && cyc == CYC_FIRST;
   assign dp_busy  = dp_op0 && cyc == CYC_BUSY;

   tcop_delay #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WRAP_SAFE(WRAP_SAFE)) dly_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .first_i (dp_first),
      .busy_i  (dp_busy),
      .delay_i (rd_dly),
      .wait_o  (dly_wait)
   );

   always_comb begin
      rsp = RSP_DONE;
      if (is_active) begin
         case (cls)
            CLS_WR, CLS_RD: rsp = RSP_DONE;
            CLS_BLD:        rsp = blk_rsp[0];
            CLS_BST:        rsp = blk_rsp[1];
            CLS_DP: begin
               if (!dp_op0)
                  rsp = RSP_CANT;
               else if (dly_wait)
                  rsp = RSP_BUSY;
               else
                  rsp = RSP_DONE;
            end
            default:        rsp = RSP_CANT;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      if (cls == CLS_RD)
         rdata_o = rd_single;
      else if (cls == CLS_BST)
         rdata_o = rd_blk;
   end

   assign resp_o = rsp;

   // R5: increment is only ever answered to a block transfer
   assert_inc_only_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_o == RSP_INC |-> (cls_i == CLS_BLD || cls_i == CLS_BST));

   // R11: idle cycles always complete
   assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_i == CYC_IDLE |-> resp_o == RSP_DONE);

   // R9: once a stall has finished, further busy cycles of it stay finished
   assert_stall_stays_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_busy && resp_o == RSP_DONE) |=>
         (!(dp_busy && $stable(instr_i)) || resp_o == RSP_DONE));

endmodule

// File: tb/tcop_top_tb.sv
module tcop_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cyc_i = 2'd0;
   logic [2:0]  cls_i = 3'd0;
   logic [31:0] instr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [1:0]  resp_o;

   int compared = 0;
   int mismatched = 0;

   always #2.5 clk = ~clk;

   tcop_top dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc_i   (cyc_i),
      .cls_i   (cls_i),
      .instr_i (instr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .resp_o  (resp_o)
   );

   typedef struct packed {
      logic [1:0]  cyc;
      logic [2:0]  cls;
      logic [31:0] instr;
      logic [31:0] wdata;
      logic [1:0]  rsp;
      logic        chk;
      logic [31:0] rdata;
      logic [7:0]  req;
   } vec_t;

   // cyc: 0 idle 1 first 2 busy 3 data; cls: 0 wr 1 rd 2 bld 3 bst 4 dp; rsp: 0 done 1 busy 2 inc 3 cant
   localparam int NV = 14;
   localparam vec_t VTAB [NV] = '{
      '{2'd3, 3'd0, 32'h0003_0000, 32'hA5A5_0003, 2'd0, 1'b0, 32'h0, 8'd2},  // R2
      '{2'd3, 3'd0, 32'h0007_0000, 32'h1234_5678, 2'd0, 1'b0, 32'h0, 8'd2},  // R2
      '{2'd3, 3'd1, 32'h0003_0000, 32'h0,         2'd0, 1'b1, 32'hA5A5_0003, 8'd3}, // R3
      '{2'd3, 3'd1, 32'h0007_0000, 32'h0,         2'd0, 1'b1, 32'h1234_5678, 8'd3}, // R3
      '{2'd1, 3'd0, 32'h0009_0000, 32'h0000_DEAD, 2'd0, 1'b0, 32'h0, 8'd2},  // R2
      '{2'd3, 3'd1, 32'h0009_0000, 32'h0,         2'd0, 1'b1, 32'h0, 8'd2},  // R2
      '{2'd1, 3'd2, 32'h0000_5000, 32'h0,         2'd0, 1'b0, 32'h0, 8'd6},  // R6
      '{2'd3, 3'd2, 32'h0000_5000, 32'h0000_0055, 2'd0, 1'b0, 32'h0, 8'd4},  // R4
      '{2'd3, 3'd1, 32'h0005_0000, 32'h0,         2'd0, 1'b1, 32'h0000_0055, 8'd4}, // R4
      '{2'd1, 3'd3, 32'h0000_7000, 32'h0,         2'd0, 1'b0, 32'h0, 8'd7},  // R7
      '{2'd3, 3'd3, 32'h0000_7000, 32'h0,         2'd0, 1'b1, 32'h1234_5678, 8'd7}, // R7
      '{2'd1, 3'd4, 32'h0030_0000, 32'h0,         2'd3, 1'b0, 32'h0, 8'd10}, // R10
      '{2'd2, 3'd4, 32'h0090_0000, 32'h0,         2'd3, 1'b0, 32'h0, 8'd10}, // R10
      '{2'd1, 3'd5, 32'h0000_0000, 32'h0,         2'd3, 1'b0, 32'h0, 8'd10}  // R10
   };

   task automatic step(input logic [1:0] cyc, input logic [2:0] cls,
                       input logic [31:0] instr, input logic [31:0] wdata,
                       input logic [1:0] exp_rsp, input logic chk,
                       input logic [31:0] exp_rd, input string req);
      @(negedge clk);
      cyc_i   = cyc;
      cls_i   = cls;
      instr_i = instr;
      wdata_i = wdata;
      #1;
      compared++;
      if (resp_o !== exp_rsp) begin
         mismatched++;
         $display("FAIL %s: resp actual %0d expected %0d", req, resp_o, exp_rsp);
      end
      if (chk) begin
         compared++;
         if (rdata_o !== exp_rd) begin
            mismatched++;
            $display("FAIL %s: rdata actual %h expected %h", req, rdata_o, exp_rd);
         end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cyc_i = 2'd0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #200000;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      do_reset();
      // R1: idle answers done and all registers read zero
      step(2'd0, 3'd0, 32'h0, 32'h0, 2'd0, 1'b0, 32'h0, "R1");
      for (int i = 0; i < 16; i++)
         step(2'd3, 3'd1, 32'(i) << 16, 32'h0, 2'd0, 1'b1, 32'h0, "R1");

      // table walk
      for (int v = 0; v < NV; v++)
         step(VTAB[v].cyc, VTAB[v].cls, VTAB[v].instr, VTAB[v].wdata,
              VTAB[v].rsp, VTAB[v].chk, VTAB[v].rdata,
              $sformatf("R%0d vec%0d", VTAB[v].req, v));

      // R5 long load to register 4: four increments then done, all to one register
      step(2'd1, 3'd2, 32'h0040_4000, 32'h0, 2'd0, 1'b0, 32'h0, "R6");
      for (int w = 0; w < 5; w++)
         step(2'd3, 3'd2, 32'h0040_4000, 32'h100 + 32'(w),
              (w == 4) ? 2'd0 : 2'd2, 1'b0, 32'h0, "R5");
      step(2'd1, 3'd2, 32'h0040_4000, 32'h0, 2'd0, 1'b0, 32'h0, "R6");
      step(2'd3, 3'd1, 32'h0004_0000, 32'h0, 2'd0, 1'b1, 32'h104, "R5");
      // R6 the first cycle above cleared the counter: full sequence again
      step(2'd1, 3'd2, 32'h0040_4000, 32'h0, 2'd0, 1'b0, 32'h0, "R6");
      for (int w = 0; w < 5; w++)
         step(2'd3, 3'd2, 32'h0040_4000, 32'h200 + 32'(w),
              (w == 4) ? 2'd0 : 2'd2, 1'b0, 32'h0, "R6");

      // R11 long store with an idle pause in the middle
      step(2'd3, 3'd0, 32'h0006_0000, 32'h0000_6666, 2'd0, 1'b0, 32'h0, "R2");
      step(2'd1, 3'd3, 32'h0040_6000, 32'h0, 2'd0, 1'b0, 32'h0, "R6");
      step(2'd3, 3'd3, 32'h0040_6000, 32'h0, 2'd2, 1'b1, 32'h0000_6666, "R7");
      step(2'd3, 3'd3, 32'h0040_6000, 32'h0, 2'd2, 1'b1, 32'h0000_6666, "R7");
      step(2'd0, 3'd3, 32'h0040_6000, 32'h0, 2'd0, 1'b0, 32'h0, "R11");
      step(2'd3, 3'd3, 32'h0040_6000, 32'h0, 2'd2, 1'b1, 32'h0000_6666, "R11");
      step(2'd3, 3'd3, 32'h0040_6000, 32'h0, 2'd2, 1'b1, 32'h0000_6666, "R11");
      step(2'd3, 3'd3, 32'h0040_6000, 32'h0, 2'd0, 1'b1, 32'h0000_6666, "R11");
      // R11 an idle write-class cycle writes nothing
      step(2'd0, 3'd0, 32'h0006_0000, 32'hFFFF_FFFF, 2'd0, 1'b0, 32'h0, "R11");
      step(2'd3, 3'd1, 32'h0006_0000, 32'h0, 2'd0, 1'b1, 32'h0000_6666, "R11");

      // delay values: r2 = 3, r0 = 0, r1 = 1
      step(2'd3, 3'd0, 32'h0002_0000, 32'd3, 2'd0, 1'b0, 32'h0, "R2");
      step(2'd3, 3'd0, 32'h0000_0000, 32'd0, 2'd0, 1'b0, 32'h0, "R2");
      step(2'd3, 3'd0, 32'h0001_0000, 32'd1, 2'd0, 1'b0, 32'h0, "R2");
      // R8 / R9 delay 3: busy, busy, busy, done
      step(2'd1, 3'd4, 32'h0000_0002, 32'h0, 2'd1, 1'b0, 32'h0, "R8");
      step(2'd2, 3'd4, 32'h0000_0002, 32'h0, 2'd1, 1'b0, 32'h0, "R9");
      step(2'd2, 3'd4, 32'h0000_0002, 32'h0, 2'd1, 1'b0, 32'h0, "R9");
      step(2'd2, 3'd4, 32'h0000_0002, 32'h0, 2'd0, 1'b0, 32'h0, "R9");
      // R8 zero delay completes at once
      step(2'd1, 3'd4, 32'h0000_0000, 32'h0, 2'd0, 1'b0, 32'h0, "R8");
      // R9 delay 1: one busy then done
      step(2'd1, 3'd4, 32'h0000_0001, 32'h0, 2'd1, 1'b0, 32'h0, "R8");
      step(2'd2, 3'd4, 32'h0000_0001, 32'h0, 2'd0, 1'b0, 32'h0, "R9");
      // R9 busy cycle arriving past the deadline finishes at once
      step(2'd1, 3'd4, 32'h0000_0002, 32'h0, 2'd1, 1'b0, 32'h0, "R8");
      for (int k = 0; k < 5; k++)
         step(2'd0, 3'd4, 32'h0000_0002, 32'h0, 2'd0, 1'b0, 32'h0, "R11");
      step(2'd2, 3'd4, 32'h0000_0002, 32'h0, 2'd0, 1'b0, 32'h0, "R9");
      // R10 unsupported opcode on a data cycle
      step(2'd3, 3'd4, 32'h0050_0002, 32'h0, 2'd3, 1'b0, 32'h0, "R10");

      // R1 a second reset clears written registers
      do_reset();
      step(2'd3, 3'd1, 32'h0003_0000, 32'h0, 2'd0, 1'b1, 32'h0, "R1");
      step(2'd3, 3'd1, 32'h0006_0000, 32'h0, 2'd0, 1'b1, 32'h0, "R1");

      @(negedge clk);
      cyc_i = 2'd0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule